// File: doc/BRIEF.md
# Chained FIFO Depth Expansion Controller

This block sits beside the storage of one FIFO and lets several identical FIFOs act as a single deeper buffer. The FIFOs form a ring. Two ownership tokens travel around the ring, one for writes and one for reads, and each token moves on its own clock domain. A device may accept a write only while it holds the write token. It may accept a read only while it holds the read token. When a device writes its own last location, it sends a one-cycle pulse to the next device and gives up the write token. When it reads its own last location, it sends a read pulse and gives up the read token in the same way.

Two straps set the role of each device. The leader strap is low on exactly one device, and that device holds both tokens when reset ends. The expansion strap selects ring operation. When it is low the device runs alone: it never gives up its tokens, its addresses wrap, and the shared write-pulse pin carries the local half-full flag from the storage core instead.

The block also supplies the local write and read addresses and accept strobes to the storage core. Each device's expansion outputs connect to the expansion inputs of the next device in the ring.

Top module: `chain_depth_ctl`

## Requirements
- R1: While reset is low, a device whose `follower` strap is 0 holds both tokens (`wr_own` = 1, `rd_own` = 1) and a device whose strap is 1 holds neither. In both cases both addresses are 0 and `rx_out` is 0. In ring mode `wx_out_hf` is also 0.
- R2: Without the write token, `wr_en` has no effect: `wr_fire` stays 0 and `wr_addr` does not change.
- R3: Without the read token, `rd_en` has no effect: `rd_fire` stays 0 and `rd_addr` does not change.
- R4: In ring mode, each accepted write advances `wr_addr` by one. A write at address DEPTH-1 returns `wr_addr` to 0. On the clock edge that takes that write, `wr_own` falls and `wx_out_hf` rises for exactly one write-clock cycle. In ring mode `wx_out_hf` does not follow `core_half`.
- R5: In ring mode, each accepted read advances `rd_addr` by one. A read at address DEPTH-1 returns `rd_addr` to 0. On the clock edge that takes that read, `rd_own` falls and `rx_out` rises for exactly one read-clock cycle.
- R6: In ring mode, a device without the write token that samples `wx_in` high on a write-clock edge holds `wr_own` = 1 from that edge on.
- R7: In ring mode, a device without the read token that samples `rx_in` high on a read-clock edge holds `rd_own` = 1 from that edge on.
- R8: With `expand_mode` = 0 and `follower` = 0, both tokens stay held. Both addresses wrap modulo DEPTH. `rx_out` stays 0. `wx_out_hf` equals `core_half`.
- R9: The write and read sides run independently. A last-location write and a last-location read taken on the same edge produce both pulses in the same cycle, and both tokens drop together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| follower | input | 1 | Strap: 0 on the ring leader, 1 on every other device |
| expand_mode | input | 1 | Strap: 1 for ring operation, 0 for a stand-alone device |
| wx_in | input | 1 | Write-token pulse from the previous device |
| rx_in | input | 1 | Read-token pulse from the previous device |
| wr_en | input | 1 | Write request, active high |
| rd_en | input | 1 | Read request, active high |
| core_half | input | 1 | Half-full indication from the local storage core |
| wr_own | output | 1 | This device holds the write token |
| rd_own | output | 1 | This device holds the read token |
| wr_fire | output | 1 | Write accepted this cycle |
| rd_fire | output | 1 | Read accepted this cycle |
| wr_addr | output | $clog2(DEPTH) | Local write address |
| rd_addr | output | $clog2(DEPTH) | Local read address |
| wx_out_hf | output | 1 | Write-token pulse in ring mode, half-full flag when stand-alone |
| rx_out | output | 1 | Read-token pulse to the next device |

## Verification
Handing off the write token and handing off the read token can happen on the same edge. To provoke this, both clocks are driven from one source and equal write and read streams run from reset. The last-location write and the last-location read then land on the same edge. The check passes only if both pulses are high in the following cycle, both tokens are gone, and both pulses are low one cycle later.

// File: rtl/chain_depth_ctl.sv
module chain_depth_ctl #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic          follower,
  input  logic          expand_mode,
  input  logic          wx_in,
  input  logic          rx_in,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          core_half,
  output logic          wr_own,
  output logic          rd_own,
  output logic          wr_fire,
  output logic          rd_fire,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic          wx_out_hf,
  output logic          rx_out
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic wr_wrap, rd_wrap, wx_q;

  assign wr_fire   = wr_en & wr_own;
  assign rd_fire   = rd_en & rd_own;
  assign wr_wrap   = wr_fire & (wr_addr == LAST);
  assign rd_wrap   = rd_fire & (rd_addr == LAST);
  assign wx_out_hf = expand_mode ? wx_q : core_half;

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_own  <= ~follower;
      wr_addr <= '0;
      wx_q    <= 1'b0;
    end else begin
      wx_q <= expand_mode & wr_wrap;
      if (wr_fire) wr_addr <= wr_wrap ? '0 : AW'(wr_addr + 1'b1);
      if (expand_mode && wr_wrap)      wr_own <= 1'b0;
      else if (expand_mode && wx_in)   wr_own <= 1'b1;
    end
  end

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_own  <= ~follower;
      rd_addr <= '0;
      rx_out  <= 1'b0;
    end else begin
      rx_out <= expand_mode & rd_wrap;
      if (rd_fire) rd_addr <= rd_wrap ? '0 : AW'(rd_addr + 1'b1);
      if (expand_mode && rd_wrap)      rd_own <= 1'b0;
      else if (expand_mode && rx_in)   rd_own <= 1'b1;
    end
  end
endmodule

// File: rtl/chain_depth_ctl_sva.sv
module chain_depth_ctl_sva #(
  parameter int AW = 8
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          rst_n,
  input logic          follower,
  input logic          expand_mode,
  input logic          wx_in,
  input logic          rx_in,
  input logic          wr_own,
  input logic          rd_own,
  input logic [AW-1:0] wr_addr,
  input logic [AW-1:0] rd_addr,
  input logic          wx_out_hf,
  input logic          rx_out
);
  p_wr_hold_r2: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !wr_own |=> $stable(wr_addr));
  p_rd_hold_r3: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !rd_own |=> $stable(rd_addr));
  p_wx_single_r4: assert property (@(posedge wr_clk) disable iff (!rst_n)
    expand_mode && wx_out_hf |=> !wx_out_hf);
  p_wx_release_r4: assert property (@(posedge wr_clk) disable iff (!rst_n)
    expand_mode && wx_out_hf |-> !wr_own);
  p_rx_single_r5: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rx_out |=> !rx_out);
  p_rx_release_r5: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rx_out |-> !rd_own);
  p_wr_take_r6: assert property (@(posedge wr_clk) disable iff (!rst_n)
    expand_mode && wx_in && !wr_own |=> wr_own);
  p_rd_take_r7: assert property (@(posedge rd_clk) disable iff (!rst_n)
    expand_mode && rx_in && !rd_own |=> rd_own);
  p_solo_tokens_r8: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !expand_mode && !follower |-> wr_own && rd_own);
  p_solo_quiet_r8: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !expand_mode |-> !rx_out);
endmodule

bind chain_depth_ctl chain_depth_ctl_sva #(.AW(AW)) u_sva (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .follower(follower),
  .expand_mode(expand_mode), .wx_in(wx_in), .rx_in(rx_in),
  .wr_own(wr_own), .rd_own(rd_own), .wr_addr(wr_addr), .rd_addr(rd_addr),
  .wx_out_hf(wx_out_hf), .rx_out(rx_out)
);

// File: tb/chain_depth_ctl_tb.sv
module chain_depth_ctl_tb_top;
  localparam int D  = 4;
  localparam int AW = $clog2(D);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic follower = 1'b0, expand_mode = 1'b1;
  logic wx_in = 1'b0, rx_in = 1'b0, wr_en = 1'b0, rd_en = 1'b0, core_half = 1'b0;
  logic wr_own, rd_own, wr_fire, rd_fire, wx_out_hf, rx_out;
  logic [AW-1:0] wr_addr, rd_addr;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  chain_depth_ctl #(.DEPTH(D)) dut_i (
    .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n), .follower(follower),
    .expand_mode(expand_mode), .wx_in(wx_in), .rx_in(rx_in),
    .wr_en(wr_en), .rd_en(rd_en), .core_half(core_half),
    .wr_own(wr_own), .rd_own(rd_own), .wr_fire(wr_fire), .rd_fire(rd_fire),
    .wr_addr(wr_addr), .rd_addr(rd_addr), .wx_out_hf(wx_out_hf), .rx_out(rx_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_reset(input logic fol, input logic exp_m);
    wr_en = 0; rd_en = 0; wx_in = 0; rx_in = 0;
    follower = fol; expand_mode = exp_m;
    rst_n = 0;
    step(); step();
    chk("R1 wr_own in reset", wr_own, !fol);
    chk("R1 rd_own in reset", rd_own, !fol);
    chk("R1 wr_addr in reset", wr_addr, 0);
    chk("R1 rd_addr in reset", rd_addr, 0);
    chk("R1 rx_out in reset", rx_out, 0);
    rst_n = 1;
    step();
  endtask

  task automatic t_leader_reset();
    do_reset(1'b0, 1'b1);
    core_half = 1; #1;
    chk("R1 wx_out_hf leader", wx_out_hf, 0);
    chk("R4 core_half not on pin in ring mode", wx_out_hf, 0);
    core_half = 0;
  endtask

  task automatic t_follower();
    do_reset(1'b1, 1'b1);
    wr_en = 1; rd_en = 1;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk("R2 wr_fire without token", wr_fire, 0);
      chk("R3 rd_fire without token", rd_fire, 0);
      step();
      chk("R2 wr_addr held", wr_addr, 0);
      chk("R3 rd_addr held", rd_addr, 0);
    end
    wr_en = 0; rd_en = 0;
    wx_in = 1; step(); wx_in = 0;
    chk("R6 write token taken", wr_own, 1);
    chk("R6 read token unaffected", rd_own, 0);
    rx_in = 1; step(); rx_in = 0;
    chk("R7 read token taken", rd_own, 1);
    step();
    chk("R6 write token kept", wr_own, 1);
  endtask

  task automatic t_write_pass();
    do_reset(1'b0, 1'b1);
    core_half = 1;
    wr_en = 1;
    for (int i = 0; i < D; i++) begin
      step();
      chk("R4 wr_addr advance", wr_addr, (i + 1) % D);
    end
    chk("R4 token released", wr_own, 0);
    chk("R4 pulse high", wx_out_hf, 1);
    step();
    chk("R4 pulse one cycle", wx_out_hf, 0);
    chk("R2 wr_addr held after release", wr_addr, 0);
    chk("R2 wr_fire after release", wr_fire, 0);
    wr_en = 0; core_half = 0;
  endtask

  task automatic t_read_pass();
    do_reset(1'b0, 1'b1);
    rd_en = 1;
    for (int i = 0; i < D; i++) begin
      step();
      chk("R5 rd_addr advance", rd_addr, (i + 1) % D);
    end
    chk("R5 token released", rd_own, 0);
    chk("R5 pulse high", rx_out, 1);
    chk("R5 write token untouched", wr_own, 1);
    step();
    chk("R5 pulse one cycle", rx_out, 0);
    chk("R3 rd_addr held after release", rd_addr, 0);
    rd_en = 0;
  endtask

  task automatic t_same_cycle();
    do_reset(1'b0, 1'b1);
    wr_en = 1; rd_en = 1;
    for (int i = 0; i < D; i++) step();
    chk("R9 write pulse", wx_out_hf, 1);
    chk("R9 read pulse", rx_out, 1);
    chk("R9 write token gone", wr_own, 0);
    chk("R9 read token gone", rd_own, 0);
    step();
    chk("R9 write pulse ends", wx_out_hf, 0);
    chk("R9 read pulse ends", rx_out, 0);
    wr_en = 0; rd_en = 0;
  endtask

  task automatic t_standalone();
    do_reset(1'b0, 1'b0);
    core_half = 1; #1;
    chk("R8 half flag high", wx_out_hf, 1);
    core_half = 0; #1;
    chk("R8 half flag low", wx_out_hf, 0);
    wr_en = 1;
    for (int i = 0; i < D + 2; i++) step();
    wr_en = 0;
    chk("R8 wr_addr wraps", wr_addr, (D + 2) % D);
    chk("R8 write token kept", wr_own, 1);
    rd_en = 1;
    for (int i = 0; i < D + 1; i++) begin
      step();
      chk("R8 rx_out quiet", rx_out, 0);
    end
    rd_en = 0;
    chk("R8 rd_addr wraps", rd_addr, (D + 1) % D);
    chk("R8 read token kept", rd_own, 1);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_leader_reset();
    t_follower();
    t_write_pass();
    t_read_pass();
    t_same_cycle();
    t_standalone();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule